// File: doc/BRIEF.md
# Boot Mode Stall Sequencer

After internal reset is released the rest of the device starts running, but the processor core is held in a stall. This sequencer decides when the core may leave that stall. A two-bit boot-select input chooses one of three boot paths. In host boot, a host sets a host-interrupt bit. In emulation boot, a debug emulator requests that bit. In ROM boot, a block copy from ROM into memory has to finish. When the stall drops, the core starts executing at a fixed address, which is zero by default.

The same host-interrupt bit later serves as the running core's host interrupt. The set that ends the stall is never passed on to the core as an interrupt. While the bit is set, further sets are not accepted. The core clears the bit with a strobe to accept the next interrupt. The host interface protocol and the copy engine are outside this block. The sequencer only requests the copy and waits for the engine's completion.

Top module: `boot_stall_seq`

## Requirements
- R1: While `rst_n` is low: `core_hold`=1, `boot_ok`=0, `copy_go`=0, `core_irq`=0, `hint_bit`=0.
- R2: `boot_sel` is sampled only on the first rising clock edge with `rst_n` high. Encoding: 2'b00 host, 2'b01 emulation, 2'b10 and 2'b11 ROM. Later changes of `boot_sel` have no effect until the next reset.
- R3: In host mode, the clock edge that sees `hint_wr` high while stalled sets `hint_bit` and drops `core_hold` together. `dbg_hint_wr` and `copy_done` do not release the stall in host mode.
- R4: In emulation or ROM mode, `hint_wr` while stalled sets `hint_bit` but leaves `core_hold` at 1.
- R5: In emulation mode, `dbg_hint_wr` while stalled releases the stall. It sets `hint_bit` if that bit is clear and leaves it set if it is already set.
- R6: In ROM mode, `copy_go` is high for exactly the one cycle after the sampling edge. The stall drops on the edge that sees `copy_done` high, and only in ROM mode.
- R7: `run_addr` equals the parameter `RUN_ADDR`, which is 0 by default.
- R8: The set of `hint_bit` that ends the stall does not produce a `core_irq` pulse.
- R9: Once running, `hint_wr` while `hint_bit`=0 sets the bit and gives a one-cycle `core_irq` pulse. While `hint_bit`=1, `hint_wr` gives no pulse.
- R10: `hint_clr` clears `hint_bit` only while the core runs. It has priority over `hint_wr` in the same cycle and is ignored while stalled.
- R11: `boot_ok` is always the complement of `core_hold`. Once high, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Internal reset, active low, asynchronous |
| boot_sel | input | 2 | Boot mode select pins |
| hint_wr | input | 1 | Host write that sets the host-interrupt bit |
| dbg_hint_wr | input | 1 | Emulator request to set the host-interrupt bit |
| hint_clr | input | 1 | Core strobe that clears the host-interrupt bit |
| copy_done | input | 1 | ROM copy engine completion |
| core_hold | output | 1 | Core stall |
| copy_go | output | 1 | One-cycle start request to the copy engine |
| boot_ok | output | 1 | Boot complete |
| run_addr | output | ADDR_W | Core start address |
| hint_bit | output | 1 | Current host-interrupt bit |
| core_irq | output | 1 | Host interrupt delivered to the running core |

## Verification
Each boot mode is offered every release source in turn: host write, emulator request and copy completion. A mode that releases on the wrong source is therefore told apart from one that releases on the right one. The stalled phase also sees clear strobes and a change of the select pins. These show that the bit is kept while stalled and that the mode is latched only on the sampling edge. After release, the host write is repeated with the bit set, after a clear, and together with a clear. This separates a correct pulse from a pulse on the release set, a pulse without a clear, or a wrong priority between clear and write.

// File: rtl/boot_stall_seq.sv
module boot_stall_seq #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RUN_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_sel,
  input  logic              hint_wr,
  input  logic              dbg_hint_wr,
  input  logic              hint_clr,
  input  logic              copy_done,
  output logic              core_hold,
  output logic              copy_go,
  output logic              boot_ok,
  output logic [ADDR_W-1:0] run_addr,
  output logic              hint_bit,
  output logic              core_irq
);
  typedef enum logic [1:0] {ST_IDLE, ST_STALL, ST_RUN} st_t;
  st_t        st;
  logic [1:0] mode_q;
  logic       m_host, m_emu, m_rom, release_now;

  assign m_host = (mode_q == 2'b00);
  assign m_emu  = (mode_q == 2'b01);
  assign m_rom  = mode_q[1];
  assign release_now = (st == ST_STALL) &&
                       ((m_host && hint_wr) || (m_emu && dbg_hint_wr) || (m_rom && copy_done));

  assign core_hold = (st != ST_RUN);
  assign boot_ok   = (st == ST_RUN);
  assign run_addr  = RUN_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mode_q   <= 2'b00;
      copy_go  <= 1'b0;
      hint_bit <= 1'b0;
      core_irq <= 1'b0;
    end else begin
      copy_go  <= 1'b0;
      core_irq <= 1'b0;
      case (st)
        ST_IDLE: begin
          mode_q  <= boot_sel;
          copy_go <= boot_sel[1];
          st      <= ST_STALL;
        end
        ST_STALL: begin
          if (hint_wr || (m_emu && dbg_hint_wr)) hint_bit <= 1'b1;
          if (release_now) st <= ST_RUN;
        end
        default: begin
          if (hint_clr) hint_bit <= 1'b0;
          else if (hint_wr && !hint_bit) begin
            hint_bit <= 1'b1;
            core_irq <= 1'b1;
          end
        end
      endcase
    end
  end

  assert_go_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |=> !copy_go);
  assert_rom_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_hold) && m_rom) |-> $past(copy_done));
  assert_host_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_hold) && m_host) |-> ($past(hint_wr) && hint_bit));
  assert_emu_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_hold) && m_emu) |-> ($past(dbg_hint_wr) && hint_bit));
  assert_no_release_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> !core_irq);
  assert_irq_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> ($past(!hint_bit) && hint_bit && boot_ok));
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ok |=> boot_ok);
endmodule

// File: tb/sim_boot_stall_seq.sv
module sim_boot_stall_seq;
  logic clk = 0, rst_n = 0;
  logic [1:0] boot_sel = 0;
  logic hint_wr = 0, dbg_hint_wr = 0, hint_clr = 0, copy_done = 0;
  logic core_hold, copy_go, boot_ok, hint_bit, core_irq;
  logic [31:0] run_addr;
  int total = 0, bad = 0;
  string tagq[$];
  logic [4:0] expq[$];

  always #10 clk = ~clk;

  boot_stall_seq u0 (.clk, .rst_n, .boot_sel, .hint_wr, .dbg_hint_wr, .hint_clr,
    .copy_done, .core_hold, .copy_go, .boot_ok, .run_addr, .hint_bit, .core_irq);

  // expected vector: {core_hold, boot_ok, copy_go, core_irq, hint_bit}
  always @(posedge clk) begin
    #5;
    if (tagq.size() > 0) begin
      string t;
      logic [4:0] e, a;
      t = tagq.pop_front();
      e = expq.pop_front();
      a = {core_hold, boot_ok, copy_go, core_irq, hint_bit};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: got %b expected %b", t, a, e);
      end
    end
  end

  task automatic step(input logic hw, dw, cl, cd, input string tag, input logic [4:0] e);
    hint_wr = hw; dbg_hint_wr = dw; hint_clr = cl; copy_done = cd;
    tagq.push_back(tag); expq.push_back(e);
    @(negedge clk);
  endtask

  task automatic boot(input logic [1:0] m);
    rst_n = 0; boot_sel = m;
    step(0,0,0,0, "R1 reset", 5'b10000);
    rst_n = 1;
    step(0,0,0,0, "R2/R6 sampling edge", {3'b101 & {2'b11, m[1]}, 2'b00});
  endtask

  initial begin
    #(200000*20);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // host mode
    boot(2'b00);
    boot_sel = 2'b10;
    step(0,0,0,0, "R2 pin change ignored", 5'b10000);
    step(0,0,0,1, "R3 copy_done no release in host", 5'b10000);
    step(0,1,0,0, "R3 emulator no release in host", 5'b10000);
    step(1,0,0,0, "R3/R8 host release", 5'b01001);
    total++;
    if (run_addr !== 32'd0) begin bad++; $display("FAIL R7: got %h expected 0", run_addr); end
    step(0,0,0,0, "R11 done held", 5'b01001);
    step(1,0,0,0, "R9 no irq while bit set", 5'b01001);
    step(0,0,1,0, "R10 clear while running", 5'b01000);
    step(1,0,0,0, "R9 irq after clear", 5'b01011);
    step(0,0,0,0, "R9 irq one cycle", 5'b01001);
    step(1,0,1,0, "R10 clear beats write", 5'b01000);
    step(1,0,0,0, "R9 irq again", 5'b01011);
    // emulation mode, bit pre-set by host
    boot(2'b01);
    step(1,0,0,0, "R4 host write in emu mode", 5'b10001);
    step(0,0,1,0, "R10 clear ignored while stalled", 5'b10001);
    step(0,0,0,1, "R6 copy_done ignored in emu", 5'b10001);
    step(0,1,0,0, "R5 emulator release bit kept", 5'b01001);
    // emulation mode, bit clear
    boot(2'b01);
    step(0,1,0,0, "R5 emulator release sets bit", 5'b01001);
    step(0,0,1,0, "R10 core clears", 5'b01000);
    // ROM mode
    boot(2'b10);
    step(0,0,0,0, "R6 copy_go single cycle", 5'b10000);
    step(1,0,0,0, "R4 host write in ROM mode", 5'b10001);
    step(0,1,1,0, "R10 clear ignored, no emu release", 5'b10001);
    step(0,0,0,1, "R6 copy done release", 5'b01001);
    // ROM via 2'b11, reset mid-run reverts
    boot(2'b11);
    step(0,0,0,0, "R6 go drops", 5'b10000);
    step(0,0,0,1, "R6 release on copy done", 5'b01000);
    step(1,0,0,0, "R9 irq in ROM boot", 5'b01011);
    rst_n = 0;
    step(0,0,0,0, "R1 reset mid-run", 5'b10000);
    while (tagq.size() > 0) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule